// File: doc/BRIEF.md
# Serial Port Register and FIFO Front End

This block is the processor-facing half of a serial port. It sits on a simple 32-bit memory-mapped bus with six word registers and holds everything software talks to: a transmit FIFO and a receive FIFO, the control word, the baud word, the interrupt level word and the sticky error flags. The serial bit engines and the baud divider sit outside it. They attach through plain valid/ready style ports. The transmit engine pulls bytes from `tx_data`. The receive engine pushes bytes and one-cycle error pulses back in.

Software programs the data length, stop length, parity and flow mode in the control word. The block forwards these fields unchanged to the engines, together with the enables and the path resets. One interrupt line combines two conditions. The receive condition is a FIFO count that has reached a programmable level. The transmit condition is a FIFO count that has fallen below its own programmable level. The error flags and the path resets act as levels: they hold their effect for as long as software leaves the bit at 1.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the control, level and baud words read 0. The status word reads 0x0050_0000, which means receive FIFO empty (bit 20) and transmit FIFO empty (bit 22). `irq` and `tx_valid` are low.
- R2: Control is fully readable and writable. Bit 12 drives `tx_en` and bit 13 drives `rx_en`. Bit 15 drives `cfg_two_wire`. Bits [17:16] drive `cfg_stop_len`, bit 18 drives `cfg_parity_odd`, bit 19 drives `cfg_parity_en` and bits [21:20] drive `cfg_data_len`. A read of an unmapped offset (0x18 to 0x1F) returns 0.
- R3: Bytes written at offset 0x00 are offered on `tx_data` in write order. `tx_valid` is high only when control bit 12 is 1 and the FIFO holds data. Each cycle with `tx_valid` and `tx_ready` both high removes one byte.
- R4: A write at offset 0x00 while the transmit FIFO holds FIFO_DEPTH (64) bytes drops the byte and sets status bit 18.
- R5: While control bit 13 is 1, each `rx_valid` cycle stores `rx_data`. Reads at offset 0x04 return the stored bytes in arrival order in bits [7:0], with bits [31:8] zero. While bit 13 is 0, incoming bytes are ignored.
- R6: A read at offset 0x04 while the receive FIFO is empty returns 0 and leaves the FIFO untouched, so the next byte that arrives is the next byte read.
- R7: A `rx_par_err` pulse sets status bit 16 and a `rx_frm_err` pulse sets status bit 17. Bits 16, 17 and 18 stay set until control bit 24 is 1. While bit 24 stays 1, the flags are held at 0 and new events are lost.
- R8: Status bit 20 shows that the receive FIFO is empty, bit 21 that the transmit FIFO is full, and bit 22 that the transmit FIFO is empty. Bit 25 follows `tx_busy`.
- R9: Control bit 22 (transmit) and control bit 23 (receive) empty their FIFO and keep it empty, ignoring pushes, for as long as the bit is 1.
- R10: The level word at offset 0x10 keeps bits [15:0], and its upper bits read 0. `irq` is high when control bit 27 is 1 and the receive FIFO count is at least bits [7:0].
- R11: `irq` is also high when control bit 28 is 1 and the transmit FIFO count is below bits [15:8].
- R12: The word at offset 0x14 is read back as written and driven on `baud_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| tx_rst | output | 1 | Transmit path reset level |
| rx_rst | output | 1 | Receive path reset level |
| cfg_data_len | output | 2 | Data length code |
| cfg_stop_len | output | 2 | Stop length code |
| cfg_parity_en | output | 1 | Parity enable |
| cfg_parity_odd | output | 1 | Odd parity select |
| cfg_two_wire | output | 1 | Flow control off (two-wire mode) |
| baud_word | output | 32 | Baud setting for the divider |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | DATA_W | Head of transmit FIFO |
| tx_ready | input | 1 | Transmit engine takes the byte |
| tx_busy | input | 1 | Transmit engine shifting a character |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | DATA_W | Received byte |
| rx_par_err | input | 1 | Parity error pulse |
| rx_frm_err | input | 1 | Framing error pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: DATA_W 8, a 64-entry FIFO and the combinational interrupt variant. It can therefore fill the transmit FIFO completely, attempt a 65th write and drain all 64 bytes, which shows that the dropped byte never reaches `tx_data`. The default combinational variant lets the bench see `irq` change in the same cycle as the FIFO count crosses a threshold, so each threshold boundary is checked one byte below and one byte at the level.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

   localparam int ADDR_W = 5;
   localparam int LVL_W  = 8;

   localparam logic [ADDR_W-1:0] OFS_TXD  = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_RXD  = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_LVL  = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_BAUD = 5'h14;

   // control bit positions
   localparam int CB_TX_EN   = 12;
   localparam int CB_RX_EN   = 13;
   localparam int CB_TWO_WR  = 15;
   localparam int CB_STOP_LO = 16;
   localparam int CB_PAR_ODD = 18;
   localparam int CB_PAR_EN  = 19;
   localparam int CB_LEN_LO  = 20;
   localparam int CB_TX_RST  = 22;
   localparam int CB_RX_RST  = 23;
   localparam int CB_ERR_CLR = 24;
   localparam int CB_RX_IE   = 27;
   localparam int CB_TX_IE   = 28;

   // status bit positions
   localparam int SB_PAR  = 16;
   localparam int SB_FRM  = 17;
   localparam int SB_TXWE = 18;
   localparam int SB_RXE  = 20;
   localparam int SB_TXF  = 21;
   localparam int SB_TXE  = 22;
   localparam int SB_BUSY = 25;

   typedef struct packed {
      logic txwe;
      logic frm;
      logic par;
   } err_flags_t;

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   input  logic                       pop,
   output logic [W-1:0]               head,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       empty,
   output logic                       full
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rf_fifo: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("uart_rf_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];
   assign count   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   a_r6_idle_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> (empty && $stable(rd_ptr)));

endmodule

// File: rtl/uart_rf_errcap.sv
module uart_rf_errcap
   import uart_regfront_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  err_flags_t set,
   output err_flags_t flags
);
   localparam int NF = $bits(err_flags_t);

   logic [NF-1:0] set_v, flag_q;
   assign set_v = set;
   assign flags = flag_q;

   for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n || clr) flag_q[i] <= 1'b0;
         else if (set_v[i]) flag_q[i] <= 1'b1;
      end

      a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && flag_q[i]) |=> flag_q[i]);
   end

   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags == '0));

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq #(
   parameter int CW        = 7,
   parameter int LW        = 8,
   parameter bit REGISTERED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_ie,
   input  logic          tx_ie,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_cnt,
   input  logic [LW-1:0] rx_lvl,
   input  logic [LW-1:0] tx_lvl,
   output logic          irq
);
   localparam int MW = (CW > LW) ? CW : LW;

   logic rx_hit, tx_hit, want;

   assign rx_hit = rx_ie && (MW'(rx_cnt) >= MW'(rx_lvl));
   assign tx_hit = tx_ie && (MW'(tx_cnt) <  MW'(tx_lvl));
   assign want   = rx_hit || tx_hit;

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= want;
      end
      assign irq = irq_q;

      a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (!rx_ie && !tx_ie) |=> !irq);
   end else begin : g_comb
      assign irq = want;

      a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (!rx_ie && !tx_ie) |-> !irq);
   end

   a_r11_tx_empty_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ie && tx_cnt == '0 && tx_lvl != '0 && !REGISTERED) |-> irq);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_regfront_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 64,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [4:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              tx_en,
   output logic              rx_en,
   output logic              tx_rst,
   output logic              rx_rst,
   output logic [1:0]        cfg_data_len,
   output logic [1:0]        cfg_stop_len,
   output logic              cfg_parity_en,
   output logic              cfg_parity_odd,
   output logic              cfg_two_wire,
   output logic [31:0]       baud_word,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              tx_busy,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   output logic              irq
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   if (DATA_W < 5 || DATA_W > 32) begin : g_bad_data_w
      $error("uart_regfront: DATA_W must lie in 5..32");
   end
   if (FIFO_DEPTH >= (1 << LVL_W)) begin : g_bad_depth
      $error("uart_regfront: FIFO_DEPTH must fit the level fields");
   end

   logic [31:0]      ctrl_q;
   logic [2*LVL_W-1:0] lvl_q;
   logic [31:0]      baud_q;

   logic wr_hit, rd_hit;
   logic tx_push_req, tx_pop, rx_push, rx_pop_req;
   logic [DATA_W-1:0] rx_head;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic tx_empty, tx_full, rx_empty, rx_full;
   err_flags_t err_set, err_q;

   assign wr_hit = bus_sel && bus_wr;
   assign rd_hit = bus_sel && !bus_wr;

   // register writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         lvl_q  <= '0;
         baud_q <= '0;
      end else if (wr_hit) begin
         case (bus_addr)
            OFS_CTRL: ctrl_q <= bus_wdata;
            OFS_LVL:  lvl_q  <= bus_wdata[2*LVL_W-1:0];
            OFS_BAUD: baud_q <= bus_wdata;
            default:  ;
         endcase
      end
   end

   // engine-side control fields
   assign tx_en          = ctrl_q[CB_TX_EN];
   assign rx_en          = ctrl_q[CB_RX_EN];
   assign tx_rst         = ctrl_q[CB_TX_RST];
   assign rx_rst         = ctrl_q[CB_RX_RST];
   assign cfg_two_wire   = ctrl_q[CB_TWO_WR];
   assign cfg_stop_len   = ctrl_q[CB_STOP_LO +: 2];
   assign cfg_parity_odd = ctrl_q[CB_PAR_ODD];
   assign cfg_parity_en  = ctrl_q[CB_PAR_EN];
   assign cfg_data_len   = ctrl_q[CB_LEN_LO +: 2];
   assign baud_word      = baud_q;

   // transmit path
   assign tx_push_req = wr_hit && (bus_addr == OFS_TXD) && !tx_rst;
   assign tx_valid    = tx_en && !tx_rst && !tx_empty;
   assign tx_pop      = tx_valid && tx_ready;

   uart_rf_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_rst),
      .push      (tx_push_req),
      .push_data (bus_wdata[DATA_W-1:0]),
      .pop       (tx_pop),
      .head      (tx_data),
      .count     (tx_cnt),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   // receive path
   assign rx_push    = rx_valid && rx_en && !rx_rst;
   assign rx_pop_req = rd_hit && (bus_addr == OFS_RXD) && !rx_rst;

   uart_rf_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_rst),
      .push      (rx_push),
      .push_data (rx_data),
      .pop       (rx_pop_req),
      .head      (rx_head),
      .count     (rx_cnt),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   // sticky errors
   always_comb begin
      err_set      = '0;
      err_set.par  = rx_par_err;
      err_set.frm  = rx_frm_err;
      err_set.txwe = tx_push_req && tx_full;
   end

   uart_rf_errcap u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctrl_q[CB_ERR_CLR]),
      .set   (err_set),
      .flags (err_q)
   );

   // interrupt
   uart_rf_irq #(.CW(CW), .LW(LVL_W), .REGISTERED(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_ie  (ctrl_q[CB_RX_IE]),
      .tx_ie  (ctrl_q[CB_TX_IE]),
      .rx_cnt (rx_cnt),
      .tx_cnt (tx_cnt),
      .rx_lvl (lvl_q[LVL_W-1:0]),
      .tx_lvl (lvl_q[2*LVL_W-1:LVL_W]),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         case (bus_addr)
            OFS_RXD:  if (!rx_empty) bus_rdata = 32'(rx_head);
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_STAT: begin
               bus_rdata[SB_PAR]  = err_q.par;
               bus_rdata[SB_FRM]  = err_q.frm;
               bus_rdata[SB_TXWE] = err_q.txwe;
               bus_rdata[SB_RXE]  = rx_empty;
               bus_rdata[SB_TXF]  = tx_full;
               bus_rdata[SB_TXE]  = tx_empty;
               bus_rdata[SB_BUSY] = tx_busy;
            end
            OFS_LVL:  bus_rdata = 32'(lvl_q);
            OFS_BAUD: bus_rdata = baud_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   a_r4_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push_req && tx_full && !ctrl_q[CB_ERR_CLR]) |=> err_q.txwe);

   a_r5_rx_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rx_rst && !rx_pop_req) |=> $stable(rx_cnt));

   a_r5_rx_full_unused: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !rx_empty);

endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
   localparam int DW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic tx_en, rx_en, tx_rst, rx_rst, cfg_parity_en, cfg_parity_odd, cfg_two_wire;
   logic [1:0] cfg_data_len, cfg_stop_len;
   logic [31:0] baud_word;
   logic tx_valid;
   logic [DW-1:0] tx_data;
   logic tx_ready = 1'b0, tx_busy = 1'b0;
   logic rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic rx_par_err = 1'b0, rx_frm_err = 1'b0;
   logic irq;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   uart_regfront u_uart_regfront (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_en(tx_en), .rx_en(rx_en), .tx_rst(tx_rst), .rx_rst(rx_rst),
      .cfg_data_len(cfg_data_len), .cfg_stop_len(cfg_stop_len),
      .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
      .cfg_two_wire(cfg_two_wire), .baud_word(baud_word),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .irq(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [4:0]  addr;
      logic [31:0] data;
      logic [7:0]  req;
   } vec_t;

   // register access table: R2 control, R10 levels, R12 baud
   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 5'h08, 32'h003F_B000, 8'd2},
      '{1'b0, 5'h08, 32'h003F_B000, 8'd2},
      '{1'b1, 5'h10, 32'h0000_1004, 8'd10},
      '{1'b0, 5'h10, 32'h0000_1004, 8'd10},
      '{1'b1, 5'h10, 32'hFFFF_FFFF, 8'd10},
      '{1'b0, 5'h10, 32'h0000_FFFF, 8'd10},
      '{1'b1, 5'h14, 32'h0180_01A0, 8'd12},
      '{1'b0, 5'h14, 32'h0180_01A0, 8'd12},
      '{1'b0, 5'h18, 32'h0000_0000, 8'd2},
      '{1'b1, 5'h10, 32'h0000_0000, 8'd10},
      '{1'b0, 5'h1C, 32'h0000_0000, 8'd2}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_err(input bit par);
      @(negedge clk);
      if (par) rx_par_err = 1'b1; else rx_frm_err = 1'b1;
      @(negedge clk);
      rx_par_err = 1'b0; rx_frm_err = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(5'h08, rd); check("R1 ctrl", rd, 32'h0);
      bus_read(5'h0C, rd); check("R1 status", rd, 32'h0050_0000);
      bus_read(5'h14, rd); check("R1 baud", rd, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (TBL[i].wr) bus_write(TBL[i].addr, TBL[i].data);
         else begin
            bus_read(TBL[i].addr, rd);
            check($sformatf("R%0d table %0d", TBL[i].req, i), rd, TBL[i].data);
         end
         if (i == 0) begin
            // R2 field forwarding after 0x003F_B000
            check("R2 fields",
                  {22'b0, tx_en, rx_en, cfg_two_wire, cfg_stop_len, cfg_parity_odd,
                   cfg_parity_en, cfg_data_len, tx_rst},
                  {22'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 2'b11, 1'b0});
         end
      end
      check("R12 baud_word", baud_word, 32'h0180_01A0);
      bus_write(5'h08, 32'h0);

      // R3 transmit order, gated by enable
      bus_write(5'h00, 32'h0000_0011);
      bus_write(5'h00, 32'h0000_0022);
      bus_write(5'h00, 32'hFFFF_FF33);
      check("R3 held while disabled", {31'b0, tx_valid}, 32'h0);
      bus_write(5'h08, 32'h0000_1000);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R3 valid", {31'b0, tx_valid}, 32'h1);
         check("R3 order", {24'b0, tx_data}, 32'h11 * (k + 1));
         tx_ready = 1'b1;
         @(negedge clk);
         tx_ready = 1'b0;
      end
      check("R3 drained", {31'b0, tx_valid}, 32'h0);

      // R8 busy flag
      tx_busy = 1'b1;
      bus_read(5'h0C, rd); check("R8 busy bit", rd & 32'h0200_0000, 32'h0200_0000);
      tx_busy = 1'b0;

      // R4 overflow with the transmitter off
      bus_write(5'h08, 32'h0);
      for (int k = 0; k < 64; k++) bus_write(5'h00, 32'(k));
      bus_read(5'h0C, rd); check("R8 tx full", rd & 32'h0064_0000, 32'h0020_0000);
      bus_write(5'h00, 32'h0000_00EE);
      bus_read(5'h0C, rd); check("R4 write error", rd & 32'h0004_0000, 32'h0004_0000);
      bus_write(5'h08, 32'h0000_1000);
      begin
         int bad = 0;
         for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!tx_valid || tx_data != 8'(k)) bad++;
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
         end
         check("R4 64 bytes intact", 32'(bad), 32'h0);
      end
      check("R4 dropped byte absent", {31'b0, tx_valid}, 32'h0);

      // R7 clear as a level, events lost while held
      bus_write(5'h08, 32'h0100_0000);
      pulse_err(1'b1);
      bus_read(5'h0C, rd); check("R7 cleared and held", rd & 32'h0007_0000, 32'h0);
      bus_write(5'h08, 32'h0);
      pulse_err(1'b0);
      bus_read(5'h0C, rd); check("R7 frame sticky", rd & 32'h0007_0000, 32'h0002_0000);
      pulse_err(1'b1);
      repeat (5) @(negedge clk);
      bus_read(5'h0C, rd); check("R7 both sticky", rd & 32'h0007_0000, 32'h0003_0000);

      // R5 receive gated by enable
      rx_byte(8'h99);
      bus_read(5'h0C, rd); check("R5 ignored when off", rd & 32'h0010_0000, 32'h0010_0000);
      bus_write(5'h08, 32'h0000_2000);
      rx_byte(8'hA5);
      rx_byte(8'h3C);
      bus_read(5'h04, rd); check("R5 first byte", rd, 32'h0000_00A5);
      bus_read(5'h04, rd); check("R5 second byte", rd, 32'h0000_003C);
      // R6 empty read
      bus_read(5'h04, rd); check("R6 empty read zero", rd, 32'h0);
      rx_byte(8'h77);
      bus_read(5'h04, rd); check("R6 pointers kept", rd, 32'h0000_0077);

      // R9 receive path reset held
      rx_byte(8'h01);
      rx_byte(8'h02);
      bus_write(5'h08, 32'h0080_2000);
      rx_byte(8'h03);
      bus_read(5'h0C, rd); check("R9 rx flushed", rd & 32'h0010_0000, 32'h0010_0000);
      bus_write(5'h08, 32'h0000_2000);
      bus_read(5'h04, rd); check("R9 no stale byte", rd, 32'h0);

      // R10 receive threshold
      bus_write(5'h10, 32'h0000_0003);
      bus_write(5'h08, 32'h0800_2000);
      rx_byte(8'h10);
      rx_byte(8'h20);
      @(negedge clk); check("R10 below level", {31'b0, irq}, 32'h0);
      rx_byte(8'h30);
      @(negedge clk); check("R10 at level", {31'b0, irq}, 32'h1);
      bus_read(5'h04, rd);
      check("R10 after read", {31'b0, irq}, 32'h0);

      // R11 transmit threshold, with R9 transmit reset
      bus_write(5'h08, 32'h0040_0000);
      bus_write(5'h00, 32'h0000_0055);
      bus_read(5'h0C, rd); check("R9 tx held empty", rd & 32'h0040_0000, 32'h0040_0000);
      bus_write(5'h10, 32'h0000_0200);
      bus_write(5'h08, 32'h1000_0000);
      @(negedge clk); check("R11 empty below level", {31'b0, irq}, 32'h1);
      bus_write(5'h00, 32'h0000_0001);
      @(negedge clk); check("R11 one below level", {31'b0, irq}, 32'h1);
      bus_write(5'h00, 32'h0000_0002);
      @(negedge clk); check("R11 at level", {31'b0, irq}, 32'h0);

      // R1 reset restores defaults
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_read(5'h0C, rd); check("R1 status after reset", rd, 32'h0050_0000);
      bus_read(5'h10, rd); check("R1 level after reset", rd, 32'h0);

      finish_run();
   end
endmodule